// File: doc/BRIEF.md
# Serial Frame Transmitter with Idle Preamble and Break Insertion

This block turns bytes into asynchronous serial frames of one start bit, eight data bits sent least significant bit first, and one stop bit, without parity. Each bit lasts from one bit-rate tick to the next. The tick is a one-cycle pulse from a baud generator outside the block. A single-entry holding register accepts the next byte while the current one is shifted out. Two status flags tell software when that register can take a new byte and when the line has gone quiet. An interrupt request combines the two flags with their enable bits.

Besides plain data frames, the block inserts two special line patterns. The first is an idle preamble: ten bit times of constant high. It is queued by turning the transmit enable off and back on while a frame is on the line. The second is a break word: ten bit times of low followed by a single high stop bit. Break words repeat for as long as the send-break control bit stays set. Clearing that bit queues exactly one more break word. Both queued patterns go out only after the frame currently on the line has finished.

The sequencer has six states. OFF drives the line high. WAKE holds the line high for the alignment tick plus one whole bit time after the enable rises. IDLE is enabled and waits for work. DATA, PRE and BRK send one frame, preamble or break word each. The transitions are: OFF to WAKE when the enable is set. WAKE, IDLE, DATA, PRE or BRK to OFF when the enable is clear: at once from WAKE and IDLE, and only at the end of a frame from the other three. WAKE to a launch on its second tick. IDLE to a launch on any tick. A frame state to a launch on the tick that ends its last bit. A launch picks the next state in fixed priority: PRE, then BRK, then DATA, then IDLE.

Top module: `sertx_core`

## Requirements
- R1: After reset, every control bit is 0, `txd` is 1, `dre` is 1, `tc` is 0 and `irq` is 0.
- R2: A write on `dat_we` while `dre` is 1 captures the byte and clears both `dre` and `tc` at that clock edge. A write while `dre` is 0 is ignored, and the held byte is kept.
- R3: A data frame on `txd` is one start bit of 0, then data bits 0 to 7 in that order, then one stop bit of 1. Each bit starts at the clock edge that samples a `bit_tick` and lasts until the next such edge. A waiting byte starts at the tick that ends the previous stop bit, with no gap.
- R4: `dre` returns to 1 at the clock edge where the held byte moves into the shifter, which is the edge that starts its start bit.
- R5: `tc` becomes 1 at the tick that ends the last bit of a frame, data or break, when no further frame is launched there and no byte is held.
- R6: When control bit 3 (transmit enable) goes from 0 to 1 while the transmitter is off, `txd` stays 1 through the first tick and through one full bit time after it. The earliest start bit begins at the second tick.
- R7: While control bit 3 is 0 and no frame is in progress, `txd` is 1 and a held byte stays held, with `dre` at 0.
- R8: Clearing control bit 3 during a frame lets that frame finish. If bit 3 is set again before the frame ends, ten bit times of 1 follow that frame, before any held byte or break.
- R9: While control bit 0 (send break) and bit 3 are both 1, the line carries back-to-back break words. Each is ten bit times of 0 followed by one bit time of 1.
- R10: Control bit 0 going from 1 to 0 queues one more break word, sent after the frame in progress ends.
- R11: `irq` is 1 exactly when (control bit 7 and `dre`) or (control bit 6 and `tc`). A write on `ctl_we` loads all four used bits (7, 6, 3, 0) at once. The other bits are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: bit 7 ready-irq enable, bit 6 done-irq enable, bit 3 transmit enable, bit 0 send break |
| dat_we | input | 1 | Holding register write strobe |
| dat_wdata | input | DATA_W | Byte to transmit |
| txd | output | 1 | Serial line, idle high |
| dre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an enable toggle, or a break-bit clear, that lands inside a frame and not at its edges. Only that turns the change into a queued preamble or break word instead of an immediate stop. The bench first locks onto the free-running bit tick. After sampling the start bit of a frame, it knows three clear cycles remain before the next tick. It uses them to drop and restore the enable and to queue the next byte. It then checks that the rest of the frame, ten bits of 1, and the queued frame appear in order. Break words are handled the same way: the bench clears send-break just after the second break word has started. It then expects exactly one more break word before the line goes idle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // sequencer states
    typedef enum logic [2:0] {
        TX_OFF  = 3'd0,
        TX_WAKE = 3'd1,
        TX_IDLE = 3'd2,
        TX_DATA = 3'd3,
        TX_PRE  = 3'd4,
        TX_BRK  = 3'd5
    } tx_state_e;

    // control register field positions (decoded by software)
    localparam int CB_RDY_IE  = 7;
    localparam int CB_DONE_IE = 6;
    localparam int CB_TX_EN   = 3;
    localparam int CB_BREAK   = 0;

endpackage

// File: rtl/sertx_ctlreg.sv
module sertx_ctlreg
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic       rdy_ie,
    output logic       done_ie,
    output logic       tx_en,
    output logic       brk_on,
    output logic       en_rise,
    output logic       brk_fall
);

    logic rsvd_bits_unused;
    assign rsvd_bits_unused = ^{ctl_wdata[5:4], ctl_wdata[2:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_ie  <= 1'b0;
            done_ie <= 1'b0;
            tx_en   <= 1'b0;
            brk_on  <= 1'b0;
        end else if (ctl_we) begin
            rdy_ie  <= ctl_wdata[CB_RDY_IE];
            done_ie <= ctl_wdata[CB_DONE_IE];
            tx_en   <= ctl_wdata[CB_TX_EN];
            brk_on  <= ctl_wdata[CB_BREAK];
        end
    end

    // one-cycle edge pulses on the write that changes the bit
    always_comb begin
        en_rise  = ctl_we &&  ctl_wdata[CB_TX_EN] && !tx_en;
        brk_fall = ctl_we && !ctl_wdata[CB_BREAK] &&  brk_on;
    end

endmodule

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              load,
    output logic              empty,
    output logic              accept,
    output logic [DATA_W-1:0] hold_q
);

    assign accept = dat_we && empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty  <= 1'b1;
            hold_q <= '0;
        end else if (accept) begin
            empty  <= 1'b0;
            hold_q <= dat_wdata;
        end else if (load) begin
            empty  <= 1'b1;
        end
    end

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRE_BITS = 10,
    parameter int BRK_LOW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_on,
    input  logic              en_rise,
    input  logic              brk_fall,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_q,
    input  logic              wr_accept,
    output logic              load,
    output logic              txd,
    output logic              tc
);

    localparam int FR_DATA = DATA_W + 2;
    localparam int FR_PRE  = PRE_BITS;
    localparam int FR_BRK  = BRK_LOW + 1;
    localparam int FR_MAX  = (FR_DATA > FR_PRE) ? ((FR_DATA > FR_BRK) ? FR_DATA : FR_BRK)
                                                : ((FR_PRE  > FR_BRK) ? FR_PRE  : FR_BRK);
    localparam int CNT_W   = $clog2(FR_MAX + 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, last_cnt;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              pend_pre_q, pend_brk_q;
    logic              launch, frame_end, take_pre, take_brk, in_frame, tc_set;

    assign in_frame = (state_q == TX_DATA) || (state_q == TX_PRE) || (state_q == TX_BRK);

    always_comb begin
        unique case (state_q)
            TX_DATA: last_cnt = CNT_W'(FR_DATA - 1);
            TX_PRE:  last_cnt = CNT_W'(FR_PRE - 1);
            TX_BRK:  last_cnt = CNT_W'(FR_BRK - 1);
            default: last_cnt = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        sh_d      = sh_q;
        launch    = 1'b0;
        frame_end = 1'b0;
        take_pre  = 1'b0;
        take_brk  = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            TX_OFF: begin
                if (tx_en) begin
                    state_d = TX_WAKE;
                    cnt_d   = '0;
                end
            end
            TX_WAKE: begin
                if (!tx_en) begin
                    state_d = TX_OFF;
                end else if (bit_tick) begin
                    if (cnt_q == CNT_W'(1)) launch = 1'b1;
                    else                    cnt_d  = cnt_q + CNT_W'(1);
                end
            end
            TX_IDLE: begin
                if (!tx_en)        state_d = TX_OFF;
                else if (bit_tick) launch  = 1'b1;
            end
            TX_DATA, TX_PRE, TX_BRK: begin
                if (bit_tick) begin
                    if (cnt_q == last_cnt) begin
                        frame_end = 1'b1;
                        if (tx_en) launch  = 1'b1;
                        else       state_d = TX_OFF;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (state_q == TX_DATA && cnt_q != '0)
                            sh_d = sh_q >> 1;
                    end
                end
            end
            default: state_d = TX_OFF;
        endcase

        // launch selection: preamble, then break, then data
        if (launch) begin
            cnt_d = '0;
            if (pend_pre_q) begin
                state_d  = TX_PRE;
                take_pre = 1'b1;
            end else if (pend_brk_q || brk_on) begin
                state_d  = TX_BRK;
                take_brk = 1'b1;
            end else if (hold_full) begin
                state_d = TX_DATA;
                load    = 1'b1;
                sh_d    = hold_q;
            end else begin
                state_d = TX_IDLE;
            end
        end
    end

    assign tc_set = frame_end && !hold_full && !take_pre && !take_brk;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // queued patterns and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pre_q <= 1'b0;
            pend_brk_q <= 1'b0;
            tc         <= 1'b0;
        end else begin
            if (en_rise && in_frame) pend_pre_q <= 1'b1;
            else if (take_pre)       pend_pre_q <= 1'b0;

            if (brk_fall)            pend_brk_q <= 1'b1;
            else if (take_brk)       pend_brk_q <= 1'b0;

            if (wr_accept)           tc <= 1'b0;
            else if (tc_set)         tc <= 1'b1;
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            TX_DATA: begin
                if (cnt_q == '0)            txd = 1'b0;
                else if (cnt_q == last_cnt) txd = 1'b1;
                else                        txd = sh_q[0];
            end
            TX_BRK:  txd = (cnt_q < CNT_W'(BRK_LOW)) ? 1'b0 : 1'b1;
            default: txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int DATA_W   = 8,
    parameter int PRE_BITS = 10,
    parameter int BRK_LOW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic              txd,
    output logic              dre,
    output logic              tc,
    output logic              irq
);

    logic              rdy_ie_w, done_ie_w, tx_en_w, brk_on_w, en_rise_w, brk_fall_w;
    logic              load_w, accept_w;
    logic [DATA_W-1:0] hold_w;

    sertx_ctlreg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .rdy_ie   (rdy_ie_w),
        .done_ie  (done_ie_w),
        .tx_en    (tx_en_w),
        .brk_on   (brk_on_w),
        .en_rise  (en_rise_w),
        .brk_fall (brk_fall_w)
    );

    sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_we   (dat_we),
        .dat_wdata(dat_wdata),
        .load     (load_w),
        .empty    (dre),
        .accept   (accept_w),
        .hold_q   (hold_w)
    );

    sertx_fsm #(.DATA_W(DATA_W), .PRE_BITS(PRE_BITS), .BRK_LOW(BRK_LOW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .tx_en    (tx_en_w),
        .brk_on   (brk_on_w),
        .en_rise  (en_rise_w),
        .brk_fall (brk_fall_w),
        .hold_full(!dre),
        .hold_q   (hold_w),
        .wr_accept(accept_w),
        .load     (load_w),
        .txd      (txd),
        .tc       (tc)
    );

    assign irq = (rdy_ie_w && dre) || (done_ie_w && tc);

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic              dat_we,
    input logic              txd,
    input logic              dre,
    input logic              tc,
    input logic              irq,
    input logic              rdy_ie,
    input logic              done_ie,
    input logic              load,
    input logic [DATA_W-1:0] hold_q
);

    // R3: the line only moves at a tick edge
    a_r3_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    // R2: an accepted write empties nothing and clears completion
    a_r2_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && dre) |=> (!dre && !tc));

    // R2: a write while full leaves the held byte alone
    a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !dre) |=> $stable(hold_q));

    // R4: empty flag only rises when the shifter takes the byte
    a_r4_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dre) |-> $past(load));

    // R5: completion only rises at a tick edge
    a_r5_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc) |-> $past(bit_tick));

    // R11: no request with both enables clear
    a_r11_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_ie && !done_ie) |-> !irq);

endmodule

bind sertx_core sertx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .dat_we  (dat_we),
    .txd     (txd),
    .dre     (dre),
    .tc      (tc),
    .irq     (irq),
    .rdy_ie  (rdy_ie_w),
    .done_ie (done_ie_w),
    .load    (load_w),
    .hold_q  (hold_w)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       txd, dre, tc, irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] tdiv = '0;

    sertx_core i_sertx_core (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .txd(txd), .dre(dre), .tc(tc), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // free-running tick every fourth cycle, changed away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv     <= '0;
            bit_tick <= 1'b0;
        end else begin
            tdiv     <= tdiv + 2'd1;
            bit_tick <= (tdiv == 2'd3);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // wait for the next tick edge, then sample the bit it started
    task automatic next_bit(output logic b);
        do @(posedge clk); while (!bit_tick);
        @(negedge clk);
        b = txd;
    endtask

    task automatic sync_tick();
        logic b;
        next_bit(b);
    endtask

    // both writes start and end at a falling edge
    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        dat_we = 1'b1; dat_wdata = v;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic expect_bits(input logic v, input int n, input string tag);
        logic b;
        for (int k = 0; k < n; k++) begin
            next_bit(b);
            chk(tag, b, v);
        end
    endtask

    // data bits and stop bit, after the start bit has been seen
    task automatic frame_rest(input logic [7:0] v);
        logic b;
        for (int k = 0; k < 8; k++) begin
            next_bit(b);
            chk("R3 data bit", b, v[k]);
        end
        next_bit(b);
        chk("R3 stop bit", b, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", txd, 1'b1);
        chk("R1 dre", dre, 1'b1);
        chk("R1 tc", tc, 1'b0);
        chk("R1 irq", irq, 1'b0);

        // enable from off, then sweep all byte values back to back
        sync_tick();
        wr_ctl(8'h08);
        wr_dat(8'h00);
        chk("R2 dre after write", dre, 1'b0);
        next_bit(b);
        chk("R6 wake bit", b, 1'b1);
        for (int i = 0; i < 256; i++) begin
            next_bit(b);
            chk("R3 start bit", b, 1'b0);
            chk("R4 dre at launch", dre, 1'b1);
            if (i < 255) begin
                wr_dat(8'(i + 1));
                wr_dat(~8'(i + 1));   // R2: ignored, register full
                chk("R2 dre held", dre, 1'b0);
            end
            frame_rest(8'(i));
        end
        next_bit(b);
        chk("R5 idle line", b, 1'b1);
        chk("R5 tc after last stop", tc, 1'b1);
        chk("R5 dre", dre, 1'b1);

        // R11 interrupt combinations
        chk("R11 no enables", irq, 1'b0);
        wr_ctl(8'h48);
        chk("R11 done enable", irq, 1'b1);
        wr_ctl(8'h88);
        chk("R11 ready enable", irq, 1'b1);
        wr_ctl(8'h48);
        wr_dat(8'hA5);
        chk("R2 tc cleared", tc, 1'b0);
        chk("R11 irq after write", irq, 1'b0);

        // R8 enable toggle inside a frame queues a preamble
        next_bit(b);
        chk("R3 start A5", b, 1'b0);
        wr_ctl(8'h40);
        wr_ctl(8'h48);
        wr_dat(8'h3C);
        frame_rest(8'hA5);
        expect_bits(1'b1, 10, "R8 preamble");
        next_bit(b);
        chk("R8 start after preamble", b, 1'b0);
        frame_rest(8'h3C);
        next_bit(b);
        chk("R5 idle", b, 1'b1);
        chk("R11 irq on done", irq, 1'b1);

        // R9 held break, R10 clear queues one more
        wr_ctl(8'h09);
        expect_bits(1'b0, 10, "R9 break low 1");
        expect_bits(1'b1, 1, "R9 break stop 1");
        next_bit(b);
        chk("R9 second break starts", b, 1'b0);
        wr_ctl(8'h08);
        expect_bits(1'b0, 9, "R9 break low 2");
        expect_bits(1'b1, 1, "R9 break stop 2");
        expect_bits(1'b0, 10, "R10 queued break low");
        expect_bits(1'b1, 1, "R10 queued break stop");
        next_bit(b);
        chk("R10 idle after break", b, 1'b1);
        chk("R5 tc after break", tc, 1'b1);

        // R7 disabled holds the byte, R6 re-enable waits one bit
        wr_ctl(8'h00);
        wr_dat(8'h5A);
        for (int k = 0; k < 6; k++) begin
            next_bit(b);
            chk("R7 line high while off", b, 1'b1);
            chk("R7 byte held", dre, 1'b0);
        end
        wr_ctl(8'h08);
        next_bit(b);
        chk("R6 wake bit after enable", b, 1'b1);
        next_bit(b);
        chk("R6 start at second tick", b, 1'b0);
        frame_rest(8'h5A);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule